// File: doc/BRIEF.md
# LFSR-Timed PWM Pulse Generator

This block turns a stream of sample bytes into a single-bit pulse-width-modulated output. The pulse is timed by a linear-feedback shift register, not by a binary counter compared against the sample. At the start of each PWM period, the most recently captured sample is loaded into a 6-bit right-shifting LFSR. The output stays high while the register steps toward its terminal state of 0x20, and it drops in the cycle that state is reached. The pulse width is therefore the number of LFSR steps the loaded code needs to reach 0x20. That mapping is monotonic in neither direction, and it matches hardware that drives a motor from a buffer of such codes.

Samples arrive on a valid strobe at any time and go into a holding register. The period-start input copies the held code into the timer. If that input arrives while a pulse is still running, the pulse is cut short. A clock-enable input, the tick, paces the stepping. When a pulse ends, the block raises a one-cycle done strobe and presents the step count on a 6-bit output.

Top module: `lfsr_pwm_gen`

## Requirements
- R1: While the reset is high, and in the first cycle after it is released, `pwm_out` and `pulse_done` are 0 and `pulse_len` is 0.
- R2: Only bits [5:0] of `sample` are used. Bits [7:6] have no effect on the pulse.
- R3: Each step shifts the LFSR one place toward bit 0, and the new bit 5 is the XOR of the old bits 0 and 1. A pulse lasts exactly as many ticks as the steps from the loaded code to 0x20.
- R4: After a `period_start` cycle that loads a code other than 0x00 or 0x20, `pwm_out` is high from the next cycle. It stays high until the edge at which the LFSR reaches 0x20, and it is low after that edge.
- R5: Loading 0x20 or 0x00 gives a zero-width period. `pwm_out` stays low and no done strobe is raised.
- R6: The LFSR steps only on cycles with `tick` high. While `tick` is low, a running pulse stays high and makes no progress.
- R7: A sample that arrives during a running pulse does not change that pulse. It is applied at the next `period_start`.
- R8: A natural pulse end raises `pulse_done` for exactly one cycle. In that cycle `pulse_len` holds the number of steps the pulse took.
- R9: A `period_start` during a running pulse ends that pulse. It raises `pulse_done` with `pulse_len` equal to the steps completed so far. In the same edge it loads the held code and starts the new period.
- R10: The held code persists. A `period_start` without a new sample reuses the last captured code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable for LFSR stepping |
| sample_valid | input | 1 | Captures `sample` into the holding register |
| sample | input | 8 | Sample byte; low 6 bits are the timing code |
| period_start | input | 1 | Starts a PWM period by loading the held code |
| pwm_out | output | 1 | PWM output, high while the LFSR is stepping |
| pulse_done | output | 1 | One-cycle strobe at the end of a pulse |
| pulse_len | output | 6 | Steps taken by the pulse that just ended |

## Verification
The bench builds the block with its defaults: a 6-bit LFSR and 8-bit samples. At these sizes every one of the 64 loadable codes can be swept, including both zero-width codes and the longest chains, which are just over 60 steps. A scoreboard of expected pulse lengths, computed from an independent model of the shift rule, covers masked upper bits, a stalled tick, a sample arriving mid-pulse, a reused held code, and a pulse cut short at five steps.

// File: rtl/lfsr_pwm_pkg.sv
package lfsr_pwm_pkg;

    localparam int unsigned DEF_CODE_W   = 6;
    localparam int unsigned DEF_SAMPLE_W = 8;
    localparam int unsigned STEP_W       = 16;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_RUN  = 1'b1
    } pwm_state_e;

    // One right shift; XOR of the two lowest bits enters at the top of a w-bit register.
    function automatic logic [STEP_W-1:0] lfsr_advance(input logic [STEP_W-1:0] s,
                                                       input int unsigned       w);
        logic [STEP_W-1:0] fb;
        fb = STEP_W'(s[0] ^ s[1]) << (w - 1);
        return (s >> 1) | fb;
    endfunction

    // Code the register must reach for the output to drop.
    function automatic logic [STEP_W-1:0] terminal_code(input int unsigned w);
        return STEP_W'(1) << (w - 1);
    endfunction

endpackage

// File: rtl/lfsr_pwm_hold.sv
module lfsr_pwm_hold
    import lfsr_pwm_pkg::*;
#(
    parameter int unsigned CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [CODE_W-1:0] cap_code,
    output logic [CODE_W-1:0] held_code
);

    logic [CODE_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (cap_en) begin
            held_q <= cap_code;
        end
    end

    assign held_code = held_q;

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> held_q == $past(cap_code));

    // R10
    keep_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(held_q));

endmodule

// File: rtl/lfsr_pwm_seed.sv
module lfsr_pwm_seed
    import lfsr_pwm_pkg::*;
#(
    parameter int unsigned CODE_W = DEF_CODE_W
) (
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] seed,
    output logic              seed_go
);

    localparam logic [CODE_W-1:0] TERM = CODE_W'(terminal_code(CODE_W));

    logic is_zero;
    logic is_term;

    assign is_zero = (code_in == '0);
    assign is_term = (code_in == TERM);

    // An all-zero code would lock the register, so it is replaced by the terminal code.
    assign seed    = is_zero ? TERM : code_in;
    assign seed_go = !(is_zero || is_term);

endmodule

// File: rtl/lfsr_pwm_timer.sv
module lfsr_pwm_timer
    import lfsr_pwm_pkg::*;
#(
    parameter int unsigned CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [CODE_W-1:0] seed,
    input  logic              seed_go,
    output logic              pwm,
    output logic              done,
    output logic [CODE_W-1:0] len
);

    localparam logic [CODE_W-1:0] TERM = CODE_W'(terminal_code(CODE_W));

    pwm_state_e        state_q;
    logic [CODE_W-1:0] lfsr_q;
    logic [CODE_W-1:0] cnt_q;
    logic              done_q;
    logic [CODE_W-1:0] len_q;
    logic [CODE_W-1:0] lfsr_nxt;
    logic [CODE_W-1:0] cnt_inc;

    assign lfsr_nxt = CODE_W'(lfsr_advance(STEP_W'(lfsr_q), CODE_W));
    assign cnt_inc  = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            lfsr_q  <= TERM;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            len_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                if (state_q == PS_RUN) begin
                    done_q <= 1'b1;
                    len_q  <= cnt_q;
                end
                lfsr_q  <= seed;
                cnt_q   <= '0;
                state_q <= seed_go ? PS_RUN : PS_IDLE;
            end else if (state_q == PS_RUN && tick) begin
                lfsr_q <= lfsr_nxt;
                cnt_q  <= cnt_inc;
                if (lfsr_nxt == TERM) begin
                    state_q <= PS_IDLE;
                    done_q  <= 1'b1;
                    len_q   <= cnt_inc;
                end
            end
        end
    end

    assign pwm  = (state_q == PS_RUN);
    assign done = done_q;
    assign len  = len_q;

    // R3
    run_code_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_RUN) |-> (lfsr_q != '0 && lfsr_q != TERM));

    // R6
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_RUN && !tick && !load) |=> ($stable(lfsr_q) && state_q == PS_RUN));

    // R8
    end_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pwm) |-> done_q);

    // R9
    cut_chk: assert property (@(posedge clk) disable iff (rst)
        (load && state_q == PS_RUN) |=> (done_q && cnt_q == '0));

endmodule

// File: rtl/lfsr_pwm_gen.sv
module lfsr_pwm_gen
    import lfsr_pwm_pkg::*;
#(
    parameter int unsigned CODE_W   = DEF_CODE_W,
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                period_start,
    output logic                pwm_out,
    output logic                pulse_done,
    output logic [CODE_W-1:0]   pulse_len
);

    logic [CODE_W-1:0] code_lo;
    logic [CODE_W-1:0] held_code;
    logic [CODE_W-1:0] seed;
    logic              seed_go;

    assign code_lo = sample[CODE_W-1:0];

    generate
        if (SAMPLE_W > CODE_W) begin : g_upper
            logic upper_bits_unused;
            assign upper_bits_unused = ^sample[SAMPLE_W-1:CODE_W];
        end
    endgenerate

    lfsr_pwm_hold #(.CODE_W(CODE_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (sample_valid),
        .cap_code  (code_lo),
        .held_code (held_code)
    );

    lfsr_pwm_seed #(.CODE_W(CODE_W)) u_seed (
        .code_in (held_code),
        .seed    (seed),
        .seed_go (seed_go)
    );

    lfsr_pwm_timer #(.CODE_W(CODE_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (period_start),
        .seed    (seed),
        .seed_go (seed_go),
        .pwm     (pwm_out),
        .done    (pulse_done),
        .len     (pulse_len)
    );

    // R5
    blank_chk: assert property (@(posedge clk) disable iff (rst)
        (period_start && !seed_go) |=> !pwm_out);

    // R1
    reset_out_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pwm_out && !pulse_done && pulse_len == '0));

endmodule

// File: tb/lfsr_pwm_gen_test.sv
module lfsr_pwm_gen_test;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       sample_valid = 1'b0;
    logic [7:0] sample = '0;
    logic       period_start = 1'b0;
    logic       pwm_out;
    logic       pulse_done;
    logic [5:0] pulse_len;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit ended = 1'b0;

    lfsr_pwm_gen uut (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .sample_valid (sample_valid),
        .sample       (sample),
        .period_start (period_start),
        .pwm_out      (pwm_out),
        .pulse_done   (pulse_done),
        .pulse_len    (pulse_len)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    function automatic int model_len(input int v);
        int s = v & 63;
        int n = 0;
        if (s == 0 || s == 32) return 0;
        while (s != 32) begin
            s = (((s ^ (s >> 1)) & 1) << 5) | (s >> 1);
            n++;
        end
        return n;
    endfunction

    // Monitor: every done strobe pops and compares one expected length (R8)
    int mon_exp;
    always @(negedge clk) begin
        if (!rst && pulse_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected done", int'(pulse_len), -1);
            end else begin
                mon_exp = exp_q.pop_front();
                check(int'(pulse_len) == mon_exp, "R8 pulse_len", int'(pulse_len), mon_exp);
            end
        end
    end

    task automatic send(input int v);
        @(negedge clk);
        sample_valid = 1'b1;
        sample = 8'(v);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic start();
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (pwm_out && n < 300) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic full(input int v, input string req);
        int n;
        int e;
        e = model_len(v);
        send(v);
        if (e > 0) exp_q.push_back(e);
        start();
        count_high(n);
        check(n == e, req, n, e);
        if (e > 0) begin
            check(pulse_done == 1'b1, "R8 strobe at end", int'(pulse_done), 1);
            @(negedge clk);
            check(pulse_done == 1'b0, "R8 strobe one cycle", int'(pulse_done), 0);
        end else begin
            repeat (3) begin
                @(negedge clk);
                check(pwm_out == 1'b0, "R5 stays low", int'(pwm_out), 0);
            end
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int n;
        int hi;
        int ea;
        int eb;
        int va;
        int vb;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R1 pwm in reset", int'(pwm_out), 0);
        check(pulse_done == 1'b0, "R1 done in reset", int'(pulse_done), 0);
        check(pulse_len == 6'd0, "R1 len in reset", int'(pulse_len), 0);
        rst = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b0 && pulse_done == 1'b0, "R1 after release", int'(pwm_out), 0);

        // R3 / R4: every loadable code
        for (int v = 0; v < 64; v++) full(v, "R3 R4 width sweep");

        // R2: upper bits ignored
        full(8'hE5, "R2 upper bits masked");
        full(8'h9F, "R2 upper bits masked");
        check(model_len(8'hE5) == model_len(8'h25), "R2 model", model_len(8'hE5), model_len(8'h25));

        // R5: zero-width codes
        full(8'h20, "R5 terminal code");
        full(8'h00, "R5 zero code");
        full(8'hA0, "R5 terminal code with upper bits");
        full(8'hC0, "R5 zero code with upper bits");

        // pick a long code and a second nonzero-width code
        va = 1;
        for (int v = 1; v < 64; v++) if (model_len(v) >= 20 && va == 1) va = v;
        vb = 8'h2A;
        if (model_len(vb) == 0) vb = 8'h01;
        ea = model_len(va);
        eb = model_len(vb);

        // R6: stalled tick holds the pulse
        tick = 1'b0;
        send(va);
        exp_q.push_back(ea);
        start();
        repeat (10) begin
            check(pwm_out == 1'b1, "R6 held while tick low", int'(pwm_out), 1);
            @(negedge clk);
        end
        tick = 1'b1;
        count_high(n);
        check(n == ea, "R6 width after stall", n, ea);
        repeat (3) @(negedge clk);

        // R7: sample mid-pulse does not disturb the running pulse
        send(va);
        exp_q.push_back(ea);
        start();
        hi = pwm_out ? 1 : 0;
        sample_valid = 1'b1;
        sample = 8'(vb);
        @(negedge clk);
        if (pwm_out) hi++;
        sample_valid = 1'b0;
        @(negedge clk);
        count_high(n);
        hi += n;
        check(hi == ea, "R7 running pulse unchanged", hi, ea);
        repeat (2) @(negedge clk);
        exp_q.push_back(eb);
        start();
        count_high(n);
        check(n == eb, "R7 new code at next period", n, eb);
        repeat (2) @(negedge clk);

        // R10: held code reused
        exp_q.push_back(eb);
        start();
        count_high(n);
        check(n == eb, "R10 reuse held code", n, eb);
        repeat (2) @(negedge clk);

        // R9: cut-off after five steps
        send(va);
        exp_q.push_back(5);
        exp_q.push_back(eb);
        start();
        sample_valid = 1'b1;
        sample = 8'(vb);
        @(negedge clk);
        sample_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(pwm_out == 1'b1, "R9 high before cut", int'(pwm_out), 1);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        check(pulse_done == 1'b1, "R9 done on cut", int'(pulse_done), 1);
        check(pulse_len == 6'd5, "R9 steps at cut", int'(pulse_len), 5);
        count_high(n);
        check(n == eb, "R9 new pulse after cut", n, eb);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R8 all pulses reported", exp_q.size(), 0);
        summary();
    end

endmodule